// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block produces a steady heartbeat interrupt for a timing subsystem. A free-running divider counts a fixed number of clock cycles, a parameter, and each time it wraps it sets a real-time flag. The divider only answers to reset. Software cannot shift its phase by clearing the flag, writing registers, or being slow to service the request, so the time between timeouts never changes.

Next to the divider sits an 8-bit enable register and an 8-bit flag register, laid out bit for bit. The real-time flag is one of four flag sources. The other three are timer overflow, counter overflow and counter edge. The logic that produces those three is outside this block, and each reaches it as a one-cycle set pulse. The block drives a single interrupt request: the OR of every flag whose enable bit is 1, delivered through a register. The enable register also holds a two-bit prescaler select field. That field is stored and brought out on a port, but this block does not act on it. Software clears a flag by writing 1 to its bit.

The register port uses plain control pins with no handshake. A write takes effect at the clock edge where `wr_en` is high. A read is combinational and returns whichever register `rd_sel` points to.

Top module: `rti_timer`

## Requirements
- R1: Real-time timeouts occur exactly every PERIOD clock cycles. Register writes and flag clears never restart or delay the divider; only reset does.
- R2: After reset is released, the first timeout sets the real-time flag on the PERIOD-th rising clock edge. Before that edge the flag reads 0.
- R3: Every timeout sets flag bit 6, whether or not the previous timeout was cleared.
- R4: Writing to the flag register (`wr_sel`=1) with a 1 in bit 7, 6, 5 or 4 clears that flag, and a 0 leaves the flag unchanged. If a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R5: The enable register (`wr_sel`=0) has these fields:
  - bit 7: timer-overflow enable
  - bit 6: real-time enable
  - bit 5: counter-overflow enable
  - bit 4: counter-edge enable
  - bits 1:0: prescaler select
  - bits 3:2: always read 0
  
  All bits are 0 after reset.
- R6: Flag bits are set by one-cycle pulses, one input per bit:
  - bit 7 from `ovf_set`
  - bit 5 from `cnt_ovf_set`
  - bit 4 from `cnt_edge_set`
  
  Flag bits 3:0 always read 0, and all flags are 0 after reset.
- R7: `irq` is registered. It equals the OR, taken over bits 7:4, of flag AND enable as they stood before the previous clock edge. With an enable bit at 0, that flag source never raises `irq`.
- R8: `presc_sel` always shows enable-register bits 1:0. Its value has no effect on the timeout spacing.
- R9: `rd_data` returns the enable register when `rd_sel`=0 and the flag register when `rd_sel`=1. Either read is combinational and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_set | input | 1 | Timer-overflow set pulse (flag bit 7) |
| cnt_ovf_set | input | 1 | Counter-overflow set pulse (flag bit 5) |
| cnt_edge_set | input | 1 | Counter-edge set pulse (flag bit 4) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable register, 1 flag register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 enable register, 1 flag register |
| rd_data | output | 8 | Read data |
| presc_sel | output | 2 | Stored prescaler select |
| irq | output | 1 | Registered interrupt request |

## Verification
The divider is first run with no register traffic at all, to show the bare timeout spacing and the first-timeout edge after reset. It is then run with flag clears and enable writes landing at random cycles. This separates a divider that is truly free-running from one that reloads or stalls on register access. Directed cases cover these situations:
- a set pulse and a clear hitting the same flag in one cycle, which shows the set-priority rule;
- writing all ones to the enable register, which shows the unimplemented bits;
- a reset in the middle of the run, which shows that the divider phase restarts.

Random enable patterns also check that `irq` follows only the enabled flags, one cycle late.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_TOVF   = 7;
  localparam int BIT_RT     = 6;
  localparam int BIT_COVF   = 5;
  localparam int BIT_CEDGE  = 4;
  localparam int SRC_LO     = 4;
  localparam int SRC_HI     = 7;
  localparam logic [REG_W-1:0] ENA_IMPL  = 8'hF3;
  localparam logic [REG_W-1:0] FLAG_IMPL = 8'hF0;

  typedef enum logic {
    SEL_ENA  = 1'b0,
    SEL_FLAG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rti_divider.sv
module rti_divider #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // Independent gap counter: cycles since reset or since last timeout
  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 32'd1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 32'(PERIOD - 1)));
  assert_no_late_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < 32'(PERIOD));
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ovf_set,
  input  logic             cnt_ovf_set,
  input  logic             cnt_edge_set,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ena_q,
  output logic [REG_W-1:0] flag_q
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic             wr_ena;
  logic             wr_flag;

  assign wr_ena  = wr_en && (reg_sel_e'(wr_sel) == SEL_ENA);
  assign wr_flag = wr_en && (reg_sel_e'(wr_sel) == SEL_FLAG);

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_TOVF]  = ovf_set;
    set_vec[BIT_RT]    = tick;
    set_vec[BIT_COVF]  = cnt_ovf_set;
    set_vec[BIT_CEDGE] = cnt_edge_set;
    clr_vec            = wr_flag ? (wr_data & FLAG_IMPL) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (wr_ena) ena_q <= wr_data & ENA_IMPL;
  end

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_flag
      if (FLAG_IMPL[gi]) begin : g_impl
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)           bit_q <= 1'b0;
          else if (set_vec[gi]) bit_q <= 1'b1;
          else if (clr_vec[gi]) bit_q <= 1'b0;
        end
        assign flag_q[gi] = bit_q;

        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
          set_vec[gi] |=> flag_q[gi]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (clr_vec[gi] && !set_vec[gi]) |=> !flag_q[gi]);
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (!clr_vec[gi] && !set_vec[gi]) |=> $stable(flag_q[gi]));
      end else begin : g_unimpl
        assign flag_q[gi] = 1'b0;
      end
    end
  endgenerate

  assert_rt_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag_q[BIT_RT]);
endmodule

// File: rtl/rti_irq.sv
module rti_irq
  import rti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] flag_q,
  input  logic [REG_W-1:0] ena_q,
  output logic             irq
);
  logic [SRC_HI-SRC_LO:0] pend;

  genvar gi;
  generate
    for (gi = SRC_LO; gi <= SRC_HI; gi++) begin : g_pend
      assign pend[gi-SRC_LO] = flag_q[gi] & ena_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pend;
  end

  assert_rt_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[BIT_RT] && ena_q[BIT_RT]) |=> irq);
  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ena_q & FLAG_IMPL) == '0) |=> !irq);
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_set,
  input  logic       cnt_ovf_set,
  input  logic       cnt_edge_set,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic [1:0] presc_sel,
  output logic       irq
);
  logic             tick;
  logic [REG_W-1:0] ena_q;
  logic [REG_W-1:0] flag_q;

  rti_divider #(.PERIOD(PERIOD)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rti_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ovf_set     (ovf_set),
    .cnt_ovf_set (cnt_ovf_set),
    .cnt_edge_set(cnt_edge_set),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .ena_q       (ena_q),
    .flag_q      (flag_q)
  );

  rti_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flag_q(flag_q),
    .ena_q (ena_q),
    .irq   (irq)
  );

  assign rd_data   = (reg_sel_e'(rd_sel) == SEL_FLAG) ? flag_q : ena_q;
  assign presc_sel = ena_q[1:0];

  assert_presc_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (presc_sel == $past(wr_data[1:0])));
endmodule

// File: tb/rti_timer_tb.sv
module rti_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf_set = 0, cnt_ovf_set = 0, cnt_edge_set = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] presc_sel;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int e_cnt = 0;
  logic [7:0] m_flag = '0, m_ena = '0;
  logic m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rti_timer #(.PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .ovf_set(ovf_set), .cnt_ovf_set(cnt_ovf_set),
    .cnt_edge_set(cnt_edge_set), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .presc_sel(presc_sel), .irq(irq)
  );

  function automatic logic [7:0] next_flags(logic [7:0] old, logic [7:0] sets, logic [7:0] clr);
    return ((old & ~clr) | sets) & 8'hF0;
  endfunction

  function automatic logic req_of(logic [7:0] f, logic [7:0] e);
    return |(f & e & 8'hF0);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %02h expected %02h", tag, e_cnt, act, exp);
    end
  endtask

  task automatic check_all();
    rd_sel = 1'b0; #1;
    chk(rd_data == m_ena, "R5 R9 enable read", rd_data, m_ena);
    rd_sel = 1'b1; #1;
    chk(rd_data == m_flag, (rd_data[6] != m_flag[6]) ? "R1 R3 rt flag" : "R4 R6 flag read",
        rd_data, m_flag);
    chk(irq == m_irq, "R7 irq", {7'd0, irq}, {7'd0, m_irq});
    chk(presc_sel == m_ena[1:0], "R8 presc_sel", {6'd0, presc_sel}, {6'd0, m_ena[1:0]});
  endtask

  task automatic step(input logic t_ovf, input logic t_cov, input logic t_ced,
                      input logic t_wr, input logic t_sel, input logic [7:0] t_data);
    logic [7:0] sets, clr, n_flag, n_ena;
    logic to, n_irq;
    ovf_set = t_ovf; cnt_ovf_set = t_cov; cnt_edge_set = t_ced;
    wr_en = t_wr; wr_sel = t_sel; wr_data = t_data;
    to     = ((e_cnt + 1) % P) == 0;
    sets   = {t_ovf, to, t_cov, t_ced, 4'b0};
    clr    = (t_wr && t_sel) ? t_data : 8'h00;
    n_flag = next_flags(m_flag, sets, clr);
    n_ena  = (t_wr && !t_sel) ? (t_data & 8'hF3) : m_ena;
    n_irq  = req_of(m_flag, m_ena);
    @(posedge clk);
    e_cnt++;
    m_flag = n_flag; m_ena = n_ena; m_irq = n_irq;
    @(negedge clk);
    ovf_set = 0; cnt_ovf_set = 0; cnt_edge_set = 0; wr_en = 0;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ovf_set = 0; cnt_ovf_set = 0; cnt_edge_set = 0; wr_en = 0;
    m_flag = '0; m_ena = '0; m_irq = 1'b0; e_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Reset state: R5 R6 R7 R8
    do_reset();

    // R2: flag 6 stays clear until edge P, set exactly on it
    for (int i = 1; i < P; i++) step(0, 0, 0, 0, 0, 8'h00);
    rd_sel = 1'b1; #1;
    chk(rd_data[6] == 1'b0, "R2 before first timeout", rd_data, 8'h00);
    step(0, 0, 0, 0, 0, 8'h00);
    rd_sel = 1'b1; #1;
    chk(rd_data[6] == 1'b1, "R2 first timeout", rd_data, 8'h40);

    // R5 R8: all-ones write, bits 3:2 read 0
    step(0, 0, 0, 1, 0, 8'hFF);
    rd_sel = 1'b0; #1;
    chk(rd_data == 8'hF3, "R5 unimplemented bits", rd_data, 8'hF3);
    chk(presc_sel == 2'b11, "R8 presc stored", {6'd0, presc_sel}, 8'h03);

    // R4: set and clear on same flag in same cycle -> set wins
    step(1, 0, 0, 1, 1, 8'h80);
    rd_sel = 1'b1; #1;
    chk(rd_data[7] == 1'b1, "R4 set wins", rd_data, 8'h80);
    // R4: write 0 leaves flags, write 1 clears
    step(0, 1, 1, 0, 0, 8'h00);
    step(0, 0, 0, 1, 1, 8'h00);
    step(0, 0, 0, 1, 1, 8'hB0);
    rd_sel = 1'b1; #1;
    chk((rd_data & 8'hB0) == 8'h00, "R4 clear by one", rd_data, 8'h00);

    // R7: only RT enabled, other sources fire
    step(0, 0, 0, 1, 0, 8'h40);
    step(0, 0, 0, 1, 1, 8'hF0);
    for (int i = 0; i < 2 * P; i++) step(1, 1, 1, 0, 0, 8'h00);

    // R1 R3: random clears and writes, divider must not shift
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] == 0, r[7:4] == 0, r[11:8] == 0, r[14:12] < 3, r[15],
           r[15] ? {r[23:20], 4'h0} : r[31:24]);
    end

    // R2 after a mid-run reset, then more random traffic
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 8'h00);
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[4:0] == 0, r[9:5] == 0, r[14:10] == 0, r[17:16] == 0, r[18],
           r[18] ? 8'hFF : r[31:24]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule